// File: doc/BRIEF.md
# Dual-Space Internal Data Memory

This block is the on-chip data store of an 8-bit microcontroller. It holds a 256-byte data RAM and a physically separate special-function-register (SFR) file. Both occupy the upper half of the 8-bit address range. The access mode decides which one is reached at an address from 80H to FFH:

- A direct access reaches the register file.
- Indirect accesses and stack operations reach the upper 128 bytes of RAM.

Addresses below 80H always reach RAM.

Each access presents an address, an access mode, read and write strobes, and write data. Reads are combinational from the selected space, and writes take effect on the clock edge.

The register file holds:

- the 8-bit stack pointer, at direct address 81H;
- a parameterized group of general registers, at F0H–F7H by default.

A direct access to any other upper address is unimplemented. It reads a fixed value, raises a flag, and any write to it is discarded.

A working-register mode maps register number 0–7 into one of four 8-byte banks at the bottom of RAM. A 2-bit bank input selects the bank.

Top module: `dual_space_dmem`

## Requirements
- R1: With mode 0 (direct), addresses 00H–7FH read and write RAM, and the same byte is visible through mode 1 (indirect).
- R2: A direct write to 80H–FFH never changes RAM; the upper RAM byte at that address keeps its value.
- R3: Mode 1 (indirect) accesses to 80H–FFH read and write upper RAM and leave every register unchanged.
- R4: Mode 3 (working register) accesses RAM address bank_i×8 + addr_i[2:0]; addr_i[7:3] is ignored.
- R5: Mode 2 (stack) with wr_i is a push. The stack pointer is first incremented modulo 256, and wdata_i is then written to RAM at the new pointer. FFH wraps to 00H.
- R6: Mode 2 with rd_i alone is a pop. rdata_o shows RAM at the current pointer, and the pointer then decrements modulo 256. 00H wraps to FFH.
- R7: In mode 2 with both strobes high, only the push is performed.
- R8: A direct read or write of an unimplemented upper address drives rdata_o to FFH and raises unimpl_o. A write there changes no state. unimpl_o is low for every other access.
- R9: After reset the stack pointer reads 07H, every general register reads 00H, and unimpl_o is low.
- R10: The stack pointer is readable and writable at direct address 81H, and general register k at direct address F0H+k.
- R11: A read in the same cycle as a write to the same location returns the old value; the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Access mode: 0 direct, 1 indirect, 2 stack, 3 working register |
| addr_i | input | 8 | Address, or register number in bits 2:0 for mode 3 |
| bank_i | input | 2 | Working-register bank select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data from the selected space |
| unimpl_o | output | 1 | Direct access to an unimplemented register |

## Verification
Two functions can fall in the same cycle: a push and a pop requested together in stack mode, and a combinational read and a clocked write of the same location. The bench provokes the first directly and through random stimulus, including at the pointer wrap. It judges that only the push happened by reading the pointer back at 81H and the pushed byte through indirect mode. For the second, the bench compares rdata_o before the edge against the model's old contents, then re-reads the location in the next access.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned AW        = 8;
  localparam int unsigned RAM_DEPTH = 1 << AW;
  localparam int unsigned REG_BITS  = 3;

  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] addr_t;

  typedef enum logic [1:0] {
    AM_DIRECT   = 2'd0,
    AM_INDIRECT = 2'd1,
    AM_STACK    = 2'd2,
    AM_WREG     = 2'd3
  } amode_e;
endpackage

// File: rtl/dmem_route.sv
module dmem_route
  import dmem_pkg::*;
(
  input  amode_e     mode_i,
  input  addr_t      addr_i,
  input  logic [1:0] bank_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  addr_t      sp_i,
  output addr_t      eff_addr_o,
  output logic       ram_we_o,
  output logic       sfr_sel_o,
  output logic       sfr_we_o,
  output logic       push_o,
  output logic       pop_o
);
  always_comb begin
    // upper half reaches registers only by direct addressing
    sfr_sel_o = (mode_i == AM_DIRECT) && addr_i[AW-1];
    push_o    = (mode_i == AM_STACK) && wr_i;
    pop_o     = (mode_i == AM_STACK) && rd_i && !wr_i;
    case (mode_i)
      AM_STACK: eff_addr_o = push_o ? addr_t'(sp_i + 1'b1) : sp_i;
      AM_WREG:  eff_addr_o = addr_t'({bank_i, addr_i[REG_BITS-1:0]});
      default:  eff_addr_o = addr_i;
    endcase
    ram_we_o = wr_i && !sfr_sel_o;
    sfr_we_o = wr_i && sfr_sel_o;
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram
  import dmem_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  addr_t addr_i,
  input  byte_t wdata_i,
  output byte_t rdata_o
);
  byte_t mem_q [RAM_DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

  // R11: write lands on the edge and is visible afterwards
  a_r11_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/dmem_sfr_file.sv
module dmem_sfr_file
  import dmem_pkg::*;
#(
  parameter int unsigned NUM_GP     = 8,
  parameter int unsigned GP_BASE    = 'hF0,
  parameter int unsigned SP_ADDR    = 'h81,
  parameter int unsigned SP_RESET   = 'h07,
  parameter int unsigned UNIMPL_VAL = 'hFF
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  addr_t addr_i,
  input  logic  sel_i,
  input  logic  access_i,
  input  logic  we_i,
  input  byte_t wdata_i,
  input  logic  push_i,
  input  logic  pop_i,
  output addr_t sp_o,
  output byte_t rdata_o,
  output logic  unimpl_o
);
  localparam addr_t SP_A   = addr_t'(SP_ADDR);
  localparam addr_t SP_R   = addr_t'(SP_RESET);
  localparam byte_t UNIMPL = byte_t'(UNIMPL_VAL);

  addr_t                          sp_q;
  logic [NUM_GP-1:0][DW-1:0]      gp_q;
  logic [NUM_GP-1:0]              gp_hit;
  logic                           sp_hit;
  logic                           any_hit;

  assign sp_hit = (addr_i == SP_A);

  for (genvar g = 0; g < NUM_GP; g++) begin : g_hit
    assign gp_hit[g] = (addr_i == addr_t'(GP_BASE + g));
  end

  assign any_hit = sp_hit || (|gp_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sp_q <= SP_R;
    else if (push_i)            sp_q <= sp_q + 1'b1;
    else if (pop_i)             sp_q <= sp_q - 1'b1;
    else if (we_i && sp_hit)    sp_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gp_q <= '0;
    end else begin
      for (int g = 0; g < NUM_GP; g++) begin
        if (we_i && gp_hit[g]) gp_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = UNIMPL;
    if (sp_hit) rdata_o = sp_q;
    for (int g = 0; g < NUM_GP; g++) begin
      if (gp_hit[g]) rdata_o = gp_q[g];
    end
  end

  assign unimpl_o = sel_i && access_i && !any_hit;
  assign sp_o     = sp_q;

  // R5: push pre-increments modulo 256
  a_r5_push_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> sp_q == addr_t'($past(sp_q) + 1'b1));
  // R6: pop post-decrements modulo 256
  a_r6_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> sp_q == addr_t'($past(sp_q) - 1'b1));
  // R3: registers hold without a direct write or a stack operation
  a_r3_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !push_i && !pop_i) |=> ($stable(sp_q) && $stable(gp_q)));
  // R8: writes to unimplemented addresses change nothing
  a_r8_unimpl_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !any_hit && !push_i && !pop_i) |=> ($stable(sp_q) && $stable(gp_q)));
endmodule

// File: rtl/dual_space_dmem.sv
module dual_space_dmem
  import dmem_pkg::*;
#(
  parameter int unsigned NUM_GP     = 8,
  parameter int unsigned GP_BASE    = 'hF0,
  parameter int unsigned SP_ADDR    = 'h81,
  parameter int unsigned SP_RESET   = 'h07,
  parameter int unsigned UNIMPL_VAL = 'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic [7:0] addr_i,
  input  logic [1:0] bank_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       unimpl_o
);
  amode_e mode;
  addr_t  eff_addr, sp;
  logic   ram_we, sfr_sel, sfr_we, push, pop;
  byte_t  ram_rdata, sfr_rdata;

  assign mode = amode_e'(mode_i);

  dmem_route u_route (
    .mode_i    (mode),
    .addr_i    (addr_i),
    .bank_i    (bank_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .sp_i      (sp),
    .eff_addr_o(eff_addr),
    .ram_we_o  (ram_we),
    .sfr_sel_o (sfr_sel),
    .sfr_we_o  (sfr_we),
    .push_o    (push),
    .pop_o     (pop)
  );

  dmem_ram u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ram_we),
    .addr_i (eff_addr),
    .wdata_i(wdata_i),
    .rdata_o(ram_rdata)
  );

  dmem_sfr_file #(
    .NUM_GP    (NUM_GP),
    .GP_BASE   (GP_BASE),
    .SP_ADDR   (SP_ADDR),
    .SP_RESET  (SP_RESET),
    .UNIMPL_VAL(UNIMPL_VAL)
  ) u_sfr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .sel_i   (sfr_sel),
    .access_i(rd_i || wr_i),
    .we_i    (sfr_we),
    .wdata_i (wdata_i),
    .push_i  (push),
    .pop_i   (pop),
    .sp_o    (sp),
    .rdata_o (sfr_rdata),
    .unimpl_o(unimpl_o)
  );

  assign rdata_o = sfr_sel ? sfr_rdata : ram_rdata;

  // R8: unimplemented access reads the fixed value
  a_r8_fixed_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unimpl_o |-> rdata_o == byte_t'(UNIMPL_VAL));
  // R2: direct upper-half write never reaches RAM
  a_r2_no_ram_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && addr_i[7] && wr_i) |-> !ram_we);
endmodule

// File: tb/tb_dual_space_dmem.sv
`timescale 1ns/1ps
module tb_dual_space_dmem;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = '0;
  logic [7:0] addr_i = '0;
  logic [1:0] bank_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       unimpl_o;

  always #10 clk = ~clk;

  dual_space_dmem dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .addr_i(addr_i),
    .bank_i(bank_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .unimpl_o(unimpl_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m_ram [256];
  logic [7:0] m_sp = 8'h07;
  logic [7:0] m_gp [8];

  function automatic bit is_gp(int a);
    return a >= 'hF0 && a <= 'hF7;
  endfunction

  function automatic bit exp_unimpl(int md, int a);
    return md == 0 && a >= 'h80 && a != 'h81 && !is_gp(a);
  endfunction

  function automatic logic [7:0] exp_rd(int md, int a, int bk);
    case (md)
      0: begin
        if (a < 'h80) return m_ram[a];
        if (a == 'h81) return m_sp;
        if (is_gp(a)) return m_gp[a - 'hF0];
        return 8'hFF;
      end
      1: return m_ram[a];
      2: return m_ram[m_sp];
      default: return m_ram[bk * 8 + (a % 8)];
    endcase
  endfunction

  function automatic string tag_for(int md, int a);
    case (md)
      0: return (a < 'h80) ? "R1" : (exp_unimpl(md, a) ? "R8" : "R10");
      1: return "R3";
      2: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic op(int md, int a, int bk, bit rd, bit wr, int wd, string req);
    @(negedge clk);
    mode_i = md[1:0]; addr_i = a[7:0]; bank_i = bk[1:0];
    rd_i = rd; wr_i = wr; wdata_i = wd[7:0];
    #2;
    if (rd && !(md == 2 && wr)) check(req, rdata_o, exp_rd(md, a, bk), "rdata");
    check(req, unimpl_o, ((rd || wr) && exp_unimpl(md, a)) ? 1 : 0, "unimpl");
    @(posedge clk);
    if (wr) begin
      case (md)
        0: begin
          if (a < 'h80) m_ram[a] = wd[7:0];
          else if (a == 'h81) m_sp = wd[7:0];
          else if (is_gp(a)) m_gp[a - 'hF0] = wd[7:0];
        end
        1: m_ram[a] = wd[7:0];
        2: begin m_sp = m_sp + 8'd1; m_ram[m_sp] = wd[7:0]; end
        default: m_ram[bk * 8 + (a % 8)] = wd[7:0];
      endcase
    end else if (rd && md == 2) begin
      m_sp = m_sp - 8'd1;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    for (int i = 0; i < 8; i++) m_gp[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 check("R9", unimpl_o, 0, "unimpl in reset");
    @(negedge clk) rst_ni = 1'b1;

    // R9: reset values
    op(0, 'h81, 0, 1, 0, 0, "R9");
    op(0, 'hF3, 0, 1, 0, 0, "R9");

    // fill RAM through indirect mode
    for (int i = 0; i < 256; i++) op(1, i, 0, 0, 1, i ^ 'h5A, "R3");

    // R1: direct and indirect see the same lower byte
    op(0, 'h20, 0, 0, 1, 'hA5, "R1");
    op(1, 'h20, 0, 1, 0, 0, "R1");
    // R3 / R2: spaces are separate in the upper half
    op(1, 'hF2, 0, 0, 1, 'h33, "R3");
    op(0, 'hF2, 0, 1, 0, 0, "R3");
    op(0, 'hF2, 0, 0, 1, 'h77, "R2");
    op(1, 'hF2, 0, 1, 0, 0, "R2");
    op(0, 'hF2, 0, 1, 0, 0, "R10");
    // R4: bank 2, register 5 is RAM 15H; high address bits ignored
    op(3, 5, 2, 0, 1, 'h4C, "R4");
    op(1, 'h15, 0, 1, 0, 0, "R4");
    op(3, 'hFD, 2, 1, 0, 0, "R4");
    // R5: push wraps pointer FFH to 00H
    op(0, 'h81, 0, 0, 1, 'hFF, "R10");
    op(2, 0, 0, 0, 1, 'h9E, "R5");
    op(0, 'h81, 0, 1, 0, 0, "R5");
    op(1, 0, 0, 1, 0, 0, "R5");
    // R6: pop at 00H reads top then wraps to FFH
    op(2, 0, 0, 1, 0, 0, "R6");
    op(0, 'h81, 0, 1, 0, 0, "R6");
    // R7: push and pop together perform only the push
    op(2, 0, 0, 1, 1, 'h61, "R7");
    op(0, 'h81, 0, 1, 0, 0, "R7");
    op(1, 0, 0, 1, 0, 0, "R7");
    op(2, 0, 0, 1, 0, 0, "R7");
    // R8: unimplemented register
    op(0, 'h90, 0, 1, 0, 0, "R8");
    op(0, 'h90, 0, 0, 1, 'h12, "R8");
    op(1, 'h90, 0, 1, 0, 0, "R8");
    op(0, 'h81, 0, 1, 0, 0, "R8");
    op(0, 'h90, 0, 0, 0, 0, "R8");
    // R11: read during write returns old value
    op(1, 'h40, 0, 1, 1, 'hC3, "R11");
    op(1, 'h40, 0, 1, 0, 0, "R11");
    op(0, 'hF5, 0, 1, 1, 'hE1, "R11");
    op(0, 'hF5, 0, 1, 0, 0, "R11");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int md, a;
      md = int'($urandom_range(0, 3));
      a  = (md == 0 && $urandom_range(0, 3) == 0) ?
           int'($urandom_range('hF0, 'hF7)) : int'($urandom_range(0, 255));
      if (md == 0 && $urandom_range(0, 7) == 0) a = 'h81;
      op(md, a, int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
         1'($urandom_range(0, 1)), int'($urandom_range(0, 255)), tag_for(md, a));
    end

    @(negedge clk);
    rd_i = 1'b0; wr_i = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule